// File: doc/BRIEF.md
# Bus-Matching Port Adapter with Byte-Order Swap

This block sits between an external clocked port and a 36-bit internal word path. The port can be set to carry a full 36-bit long word per transfer, an 18-bit half, or a single 9-bit byte. When writing, the adapter gathers narrow transfers into one long word and hands it inward over a valid/ready handshake. When reading, it takes a long word offered from inside and presents it to the port one slice at a time. A fourth size code bypasses the word path entirely and reaches a 36-bit mailbox register held elsewhere.

The size, swap and endian selects are registered on every rising edge, and each transfer uses the value registered on the edge before it. Once the first slice of a long word has moved, that configuration is frozen until the last slice completes. A byte-order permutation is applied to each whole long word. On the write side it is applied after the slices are assembled, and on the read side before the word is cut into slices.

Top module: `bus_match_adapter`

## Requirements
- R1: While `rst_n` is low, `up_valid` and `dn_ready` are 0. The registered configuration resets to size 00 (36-bit), swap 00 and big-endian, so a transfer on the first edge after release moves one full long word.
- R2: The `size_sel`, `swap_sel` and `big_end` values sampled on one rising edge govern transfers from the next rising edge on, never the edge on which they are sampled.
- R3: With size code 00, each accepted port transfer moves one complete 36-bit long word.
- R4: Size code 01 takes two transfers per long word on port bits [17:0], and size code 10 takes four on bits [8:0]. With `big_end`=1 the most significant slice moves first; with 0 the least significant slice moves first.
- R5: The four swap codes act on the four 9-bit lanes (lane 0 = bits [8:0]): 00 none; 01 reverses all four lanes; 10 exchanges the 18-bit halves; 11 exchanges the two lanes inside each half. For writes, the inward word is the swap of the assembled port-order word. For reads, the port-order word is the swap of the inward word.
- R6: Size, swap and endian are locked at the first slice of a long word. Changes on the inputs before the last slice have no effect on that long word.
- R7: Size code 11 is a mailbox access and needs only one transfer. A write pulses `mbx_wr` with the port data unswapped and produces no inward word. A read returns `mbx_rdata` on `port_rdata`. `port_ready` is 1 for mailbox accesses.
- R8: A write slice that completes a long word is accepted only if the inward holding register is empty or being drained in the same cycle. `up_data` stays stable while `up_valid` is high and `up_ready` is low.
- R9: For non-mailbox reads, `port_ready` equals `dn_valid`. `dn_ready` pulses only on the final slice of a long word. Unused upper lanes of `port_rdata` read as 0 in narrow modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Transfer request on this edge |
| port_wr | input | 1 | 1 = write into block, 0 = read from block |
| size_sel | input | 2 | Bus size code (00 long, 01 half, 10 byte, 11 mailbox) |
| swap_sel | input | 2 | Lane swap code |
| big_end | input | 1 | 1 = most significant slice first |
| port_wdata | input | 36 | Write data from port |
| port_rdata | output | 36 | Read data to port |
| port_ready | output | 1 | Transfer accepted when high with `port_en` |
| up_valid | output | 1 | Packed long word available inward |
| up_ready | input | 1 | Inward sink accepts word |
| up_data | output | 36 | Packed long word |
| dn_valid | input | 1 | Inward source offers a word |
| dn_ready | output | 1 | Word consumed (last slice read) |
| dn_data | input | 36 | Word to be unpacked |
| mbx_wr | output | 1 | Mailbox write strobe |
| mbx_wdata | output | 36 | Mailbox write data |
| mbx_rdata | input | 36 | Mailbox read data |

## Verification
The bench changes the selects on the same edge as a transfer. A design that applied them one edge early would send a long word out after one byte beat, or wait for four beats after a long-mode transfer. Selects are also changed between the beats of a byte-mode long word. A design without the lock would mix slice positions or swap patterns inside one word. It runs each swap code in both directions and with both endian settings, where a wrong lane map or reversed beat order shows up as scrambled lanes. It also stalls the inward sink, so a design that overwrote the holding register would lose or change a word, and it mixes mailbox accesses between data words, where a leak would create a spurious inward word or a `dn_ready` pulse.

// File: rtl/bma_pkg.sv
package bma_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_MBOX = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    SW_NONE  = 2'b00,
    SW_REV   = 2'b01,
    SW_HALF  = 2'b10,
    SW_INNER = 2'b11
  } swap_e;

  typedef struct packed {
    size_e size;
    swap_e swap;
    logic  be;
  } cfg_t;

  // index of the final slice of a long word for a given size
  function automatic logic [1:0] last_slice(size_e s);
    case (s)
      SZ_HALF: last_slice = 2'd1;
      SZ_BYTE: last_slice = 2'd3;
      default: last_slice = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bma_cfg_capture.sv
module bma_cfg_capture
  import bma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_in,
  input  logic [1:0] swap_in,
  input  logic       be_in,
  output cfg_t       cfg_q
);

  cfg_t cfg_d;

  always_comb begin
    cfg_d.size = size_e'(size_in);
    cfg_d.swap = swap_e'(swap_in);
    cfg_d.be   = be_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.size <= SZ_LONG;
      cfg_q.swap <= SW_NONE;
      cfg_q.be   <= 1'b1;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // R2
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cfg_q == $past(cfg_d)));

endmodule

// File: rtl/bma_swap.sv
module bma_swap
  import bma_pkg::*;
#(
  parameter  int BYTE_W = 9,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  swap_e             mode,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int REV_SRC   = LANES - 1 - i;
    localparam int HALF_SRC  = (i + LANES / 2) % LANES;
    localparam int INNER_SRC = i ^ 1;
    logic [BYTE_W-1:0] o;

    always_comb begin
      case (mode)
        SW_REV:   o = din[REV_SRC*BYTE_W +: BYTE_W];
        SW_HALF:  o = din[HALF_SRC*BYTE_W +: BYTE_W];
        SW_INNER: o = din[INNER_SRC*BYTE_W +: BYTE_W];
        default:  o = din[i*BYTE_W +: BYTE_W];
      endcase
    end

    assign dout[i*BYTE_W +: BYTE_W] = o;
  end

endmodule

// File: rtl/bma_pack.sv
module bma_pack
  import bma_pkg::*;
#(
  parameter  int BYTE_W = 9,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  cfg_t              cfg_q,
  input  logic [WORD_W-1:0] wdata,
  output logic              ready,
  output logic              is_mbox,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);

  logic [1:0]        cnt_q, cnt_d;
  cfg_t              lock_q, lock_d;
  cfg_t              act;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] merged, swapped;
  logic              out_v_q, out_v_d;
  logic [WORD_W-1:0] out_d_q, out_d_d;
  logic [1:0]        last_idx, part;
  logic              is_last, fire;

  always_comb begin
    act      = (cnt_q == 2'd0) ? cfg_q : lock_q;
    last_idx = last_slice(act.size);
    is_last  = (cnt_q == last_idx);
    is_mbox  = (act.size == SZ_MBOX);
    part     = act.be ? (last_idx - cnt_q) : cnt_q;
    ready    = !is_last || !out_v_q || out_ready;
    fire     = en && !is_mbox && ready;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_merge
    localparam logic [1:0] HALF_PART = 2'(j / 2);
    localparam logic [1:0] BYTE_PART = 2'(j);
    localparam int         HALF_SRC  = j % 2;
    logic [BYTE_W-1:0] m;

    always_comb begin
      m = acc_q[j*BYTE_W +: BYTE_W];
      case (act.size)
        SZ_HALF: if (part == HALF_PART) m = wdata[HALF_SRC*BYTE_W +: BYTE_W];
        SZ_BYTE: if (part == BYTE_PART) m = wdata[BYTE_W-1:0];
        default: m = wdata[j*BYTE_W +: BYTE_W];
      endcase
    end

    assign merged[j*BYTE_W +: BYTE_W] = m;
  end

  bma_swap #(.BYTE_W(BYTE_W)) u_swap (
    .mode (act.swap),
    .din  (merged),
    .dout (swapped)
  );

  always_comb begin
    cnt_d   = cnt_q;
    lock_d  = lock_q;
    acc_d   = acc_q;
    out_v_d = out_v_q;
    out_d_d = out_d_q;
    if (out_v_q && out_ready) out_v_d = 1'b0;
    if (fire) begin
      acc_d = merged;
      if (cnt_q == 2'd0) lock_d = cfg_q;
      if (is_last) begin
        cnt_d   = 2'd0;
        out_v_d = 1'b1;
        out_d_d = swapped;
      end else begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= 2'd0;
      lock_q  <= '0;
      acc_q   <= '0;
      out_v_q <= 1'b0;
      out_d_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      lock_q  <= lock_d;
      acc_q   <= acc_d;
      out_v_q <= out_v_d;
      out_d_q <= out_d_d;
    end
  end

  assign out_valid = out_v_q;
  assign out_data  = out_d_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v_q && !out_ready) |=> (out_v_q && $stable(out_d_q)));

  // R6
  pack_mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != 2'd0) |-> (act.size == SZ_HALF || act.size == SZ_BYTE));

  // R4
  pack_half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act.size == SZ_HALF) |-> (cnt_q <= 2'd1));

endmodule

// File: rtl/bma_unpack.sv
module bma_unpack
  import bma_pkg::*;
#(
  parameter  int BYTE_W = 9,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  cfg_t              cfg_q,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              is_mbox,
  output logic [WORD_W-1:0] rdata
);

  logic [1:0]        cnt_q, cnt_d;
  cfg_t              lock_q, lock_d;
  cfg_t              act;
  logic [WORD_W-1:0] view;
  logic [1:0]        last_idx, part;
  logic              is_last, fire;

  always_comb begin
    act      = (cnt_q == 2'd0) ? cfg_q : lock_q;
    last_idx = last_slice(act.size);
    is_last  = (cnt_q == last_idx);
    is_mbox  = (act.size == SZ_MBOX);
    part     = act.be ? (last_idx - cnt_q) : cnt_q;
    fire     = en && !is_mbox && in_valid;
    in_ready = fire && is_last;
  end

  bma_swap #(.BYTE_W(BYTE_W)) u_swap (
    .mode (act.swap),
    .din  (in_data),
    .dout (view)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_slice
    localparam logic [1:0] LN = 2'(l);
    logic [1:0]        sel;
    logic              vld;
    logic [BYTE_W-1:0] o;

    always_comb begin
      case (act.size)
        SZ_HALF: begin
          vld = (LN < 2'd2);
          sel = {part[0], LN[0]};
        end
        SZ_BYTE: begin
          vld = (LN == 2'd0);
          sel = part;
        end
        default: begin
          vld = 1'b1;
          sel = LN;
        end
      endcase
      o = vld ? view[sel*BYTE_W +: BYTE_W] : '0;
    end

    assign rdata[l*BYTE_W +: BYTE_W] = o;
  end

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (fire) begin
      if (cnt_q == 2'd0) lock_d = cfg_q;
      cnt_d = is_last ? 2'd0 : (cnt_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 2'd0;
      lock_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  // R6
  unpack_mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != 2'd0) |-> (act.size == SZ_HALF || act.size == SZ_BYTE));

  // R9
  unpack_mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != 2'd0 && !in_valid) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/bus_match_adapter.sv
module bus_match_adapter
  import bma_pkg::*;
#(
  parameter  int BYTE_W = 9,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              port_wr,
  input  logic [1:0]        size_sel,
  input  logic [1:0]        swap_sel,
  input  logic              big_end,
  input  logic [WORD_W-1:0] port_wdata,
  output logic [WORD_W-1:0] port_rdata,
  output logic              port_ready,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [WORD_W-1:0] up_data,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic [WORD_W-1:0] dn_data,
  output logic              mbx_wr,
  output logic [WORD_W-1:0] mbx_wdata,
  input  logic [WORD_W-1:0] mbx_rdata
);

  cfg_t              cfg_q;
  logic              pk_ready, pk_mbox, un_mbox;
  logic [WORD_W-1:0] un_rdata;

  bma_cfg_capture u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .size_in (size_sel),
    .swap_in (swap_sel),
    .be_in   (big_end),
    .cfg_q   (cfg_q)
  );

  bma_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (port_en && port_wr),
    .cfg_q     (cfg_q),
    .wdata     (port_wdata),
    .ready     (pk_ready),
    .is_mbox   (pk_mbox),
    .out_valid (up_valid),
    .out_ready (up_ready),
    .out_data  (up_data)
  );

  bma_unpack #(.BYTE_W(BYTE_W)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (port_en && !port_wr),
    .cfg_q    (cfg_q),
    .in_valid (dn_valid),
    .in_data  (dn_data),
    .in_ready (dn_ready),
    .is_mbox  (un_mbox),
    .rdata    (un_rdata)
  );

  always_comb begin
    if (port_wr) port_ready = pk_mbox || pk_ready;
    else         port_ready = un_mbox || dn_valid;
    port_rdata = un_mbox ? mbx_rdata : un_rdata;
    mbx_wr     = port_en && port_wr && pk_mbox;
    mbx_wdata  = port_wdata;
  end

  // R7
  mbox_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_wr && !up_valid) |=> !up_valid);

endmodule

// File: tb/bus_match_adapter_tb.sv
module bus_match_adapter_tb;

  localparam int BW = 9;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          port_en, port_wr, big_end, up_ready, dn_valid;
  logic [1:0]    size_sel, swap_sel;
  logic [WW-1:0] port_wdata, dn_data, mbx_rdata;
  logic [WW-1:0] port_rdata, up_data, mbx_wdata;
  logic          port_ready, up_valid, dn_ready, mbx_wr;

  always #10 clk = ~clk;

  bus_match_adapter u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_wr(port_wr),
    .size_sel(size_sel), .swap_sel(swap_sel), .big_end(big_end),
    .port_wdata(port_wdata), .port_rdata(port_rdata), .port_ready(port_ready),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .mbx_wr(mbx_wr), .mbx_wdata(mbx_wdata), .mbx_rdata(mbx_rdata)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R1";

  // reference model state
  int           q_size = 0, q_swap = 0, q_be = 1;
  int           p_cnt = 0, p_size = 0, p_swap = 0, p_be = 1;
  int           u_cnt = 0, u_size = 0, u_swap = 0, u_be = 1;
  logic [BW-1:0] acc [4];
  logic          m_upv = 1'b0;
  logic [WW-1:0] m_upd = '0;
  int            dn_seq = 0;
  logic          dn_pend = 1'b0;

  function automatic int nbeats(int s);
    if (s == 1) return 2;
    if (s == 2) return 4;
    return 1;
  endfunction

  function automatic int xmask(int sw);
    case (sw)
      1: return 3;
      2: return 2;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [BW-1:0] lane_of(logic [WW-1:0] w, int i);
    return w[i*BW +: BW];
  endfunction

  function automatic logic [WW-1:0] pat(int k);
    logic [WW-1:0] w;
    for (int b = 0; b < 4; b++) w[b*BW +: BW] = BW'(k * 41 + b * 7 + 19);
    return w;
  endfunction

  task automatic check(string sig, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", phase, sig, act, exp);
    end
  endtask

  task automatic cyc(int en, int wr, int sz, int sw, int be, logic [WW-1:0] wd,
                     int upr, int dnv);
    int asz, asw, abe, nb, c, part;
    logic plast, pmb, ulast, umb, exp_rdy, pfire, ufire;
    logic [WW-1:0] exp_rd;
    port_en = en[0]; port_wr = wr[0]; size_sel = 2'(sz); swap_sel = 2'(sw);
    big_end = be[0]; port_wdata = wd; up_ready = upr[0]; dn_valid = dnv[0];
    if (dn_pend) begin dn_seq++; dn_data = pat(dn_seq); dn_pend = 1'b0; end
    #8;
    // write side expectation
    asz = (p_cnt == 0) ? q_size : p_size;
    nb = nbeats(asz);
    plast = (p_cnt == nb - 1);
    pmb = (asz == 3);
    // read side expectation
    begin
      int rsz, rsw, rbe, rnb, rc, rpart;
      rsz = (u_cnt == 0) ? q_size : u_size;
      rsw = (u_cnt == 0) ? q_swap : u_swap;
      rbe = (u_cnt == 0) ? q_be : u_be;
      rnb = nbeats(rsz);
      ulast = (u_cnt == rnb - 1);
      umb = (rsz == 3);
      exp_rd = '0;
      if (umb) exp_rd = mbx_rdata;
      else begin
        rc = 4 / rnb;
        rpart = rbe ? (rnb - 1 - u_cnt) : u_cnt;
        for (int l = 0; l < rc; l++)
          exp_rd[l*BW +: BW] = lane_of(dn_data, (rpart * rc + l) ^ xmask(rsw));
      end
    end
    if (wr != 0) exp_rdy = pmb || !plast || !m_upv || (upr != 0);
    else         exp_rdy = umb || (dnv != 0);
    check("port_ready", WW'(port_ready), WW'(exp_rdy));
    check("port_rdata", port_rdata, exp_rd);
    check("dn_ready", WW'(dn_ready),
          WW'((en != 0) && (wr == 0) && !umb && (dnv != 0) && ulast));
    check("mbx_wr", WW'(mbx_wr), WW'((en != 0) && (wr != 0) && pmb));
    if ((en != 0) && (wr != 0) && pmb) check("mbx_wdata", mbx_wdata, wd);
    check("up_valid", WW'(up_valid), WW'(m_upv));
    if (m_upv) check("up_data", up_data, m_upd);
    // model update at the coming edge
    pfire = (en != 0) && (wr != 0) && !pmb && exp_rdy;
    if (m_upv && upr != 0) m_upv = 1'b0;
    if (pfire) begin
      if (p_cnt == 0) begin p_size = q_size; p_swap = q_swap; p_be = q_be; end
      asw = p_swap; abe = p_be;
      c = 4 / nb;
      part = abe ? (nb - 1 - p_cnt) : p_cnt;
      for (int l = 0; l < c; l++) acc[part * c + l] = lane_of(wd, l);
      if (plast) begin
        m_upv = 1'b1;
        for (int i = 0; i < 4; i++) m_upd[i*BW +: BW] = acc[i ^ xmask(asw)];
        p_cnt = 0;
      end else p_cnt++;
    end
    ufire = (en != 0) && (wr == 0) && !umb && (dnv != 0);
    if (ufire) begin
      if (u_cnt == 0) begin u_size = q_size; u_swap = q_swap; u_be = q_be; end
      if (ulast) begin u_cnt = 0; dn_pend = 1'b1; end
      else u_cnt++;
    end
    q_size = sz; q_swap = sw; q_be = be;
    @(negedge clk);
  endtask

  function automatic logic [WW-1:0] wv(int k);
    return pat(k + 1000);
  endfunction

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; port_en = 0; port_wr = 1; size_sel = 2'd2; swap_sel = 2'd1;
    big_end = 0; port_wdata = '0; up_ready = 1; dn_valid = 0;
    dn_data = pat(0); mbx_rdata = 36'h9_A5C3_7E1B;
    for (int i = 0; i < 4; i++) acc[i] = '0;
    repeat (3) @(negedge clk);
    phase = "R1";
    check("up_valid", WW'(up_valid), '0);
    check("dn_ready", WW'(dn_ready), '0);
    // release and transfer at once: reset config (long, no swap) applies
    rst_n = 1'b1;
    cyc(1, 1, 2, 1, 0, wv(1), 1, 0);
    // R2: byte size was sampled above; now takes effect
    phase = "R2";
    cyc(1, 1, 2, 0, 1, wv(2), 1, 0);
    cyc(1, 1, 2, 0, 1, wv(3), 1, 0);
    cyc(1, 1, 2, 0, 1, wv(4), 1, 0);
    cyc(1, 1, 0, 0, 1, wv(5), 1, 0);
    cyc(1, 1, 0, 0, 1, wv(6), 1, 0);
    // R3 / R5: long words in each swap mode
    phase = "R5";
    for (int s = 0; s < 4; s++) begin
      cyc(0, 1, 0, s, 1, '0, 1, 0);
      cyc(1, 1, 0, s, 1, wv(10 + s), 1, 0);
    end
    phase = "R3";
    cyc(1, 1, 0, 0, 1, wv(20), 1, 0);
    cyc(0, 1, 1, 0, 1, '0, 1, 0);
    // R4: half mode big and little endian, byte mode little endian
    phase = "R4";
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, 2, 1, wv(30 + k), 1, 0);
    cyc(0, 1, 1, 3, 0, '0, 1, 0);
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, 3, 0, wv(40 + k), 1, 0);
    cyc(0, 1, 2, 1, 0, '0, 1, 0);
    for (int k = 0; k < 4; k++) cyc(1, 1, 2, 1, 0, wv(50 + k), 1, 0);
    // R6: selects change between slices
    phase = "R6";
    cyc(0, 1, 2, 2, 1, '0, 1, 0);
    cyc(1, 1, 0, 1, 0, wv(60), 1, 0);
    cyc(1, 1, 1, 3, 0, wv(61), 1, 0);
    cyc(0, 1, 3, 0, 1, '0, 1, 0);
    cyc(1, 1, 3, 0, 1, wv(62), 1, 0);
    cyc(1, 1, 0, 0, 1, wv(63), 1, 0);
    cyc(1, 1, 0, 0, 1, wv(64), 1, 0);
    // R8: sink stalls
    phase = "R8";
    cyc(1, 1, 0, 2, 1, wv(70), 0, 0);
    cyc(1, 1, 0, 2, 1, wv(71), 0, 0);
    cyc(1, 1, 0, 2, 1, wv(72), 0, 0);
    cyc(0, 1, 1, 2, 1, '0, 1, 0);
    cyc(1, 1, 1, 2, 1, wv(73), 0, 0);
    cyc(1, 1, 1, 2, 1, wv(74), 0, 0);
    cyc(1, 1, 1, 2, 1, wv(75), 0, 0);
    cyc(1, 1, 1, 2, 1, wv(76), 1, 0);
    cyc(0, 1, 0, 0, 1, '0, 1, 0);
    // R7: mailbox write and read between data words
    phase = "R7";
    cyc(0, 1, 3, 1, 1, '0, 0, 0);
    cyc(1, 1, 3, 1, 1, wv(80), 0, 0);
    cyc(1, 0, 3, 1, 1, '0, 1, 1);
    cyc(1, 0, 0, 0, 1, '0, 1, 1);
    // R9: reads in every size, endian and swap, with source gaps
    phase = "R9";
    cyc(1, 0, 0, 0, 1, '0, 1, 1);
    cyc(0, 0, 1, 1, 1, '0, 1, 1);
    for (int k = 0; k < 5; k++) cyc(1, 0, 1, 1, 1, '0, 1, (k == 1) ? 0 : 1);
    cyc(0, 0, 2, 2, 0, '0, 1, 1);
    for (int k = 0; k < 6; k++) cyc(1, 0, 2, 2, 0, '0, 1, (k == 2) ? 0 : 1);
    phase = "R5";
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 2, s, s % 2, '0, 1, 1);
      for (int k = 0; k < 4; k++) cyc(1, 0, 2, s, s % 2, '0, 1, 1);
    end
    phase = "R6";
    cyc(0, 0, 2, 3, 1, '0, 1, 1);
    cyc(1, 0, 1, 0, 0, '0, 1, 1);
    cyc(1, 0, 3, 2, 0, '0, 1, 1);
    cyc(1, 0, 0, 1, 1, '0, 1, 1);
    cyc(1, 0, 0, 1, 1, '0, 1, 1);
    cyc(1, 0, 0, 1, 1, '0, 1, 1);
    cyc(0, 0, 0, 0, 1, '0, 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule